// File: doc/BRIEF.md
# External Memory Strobe Timing Controller

This block connects a synchronous core to an asynchronous parallel memory bus. The core hands it one access at a time, a read or a write with an address and write data, over a valid/ready request channel. The block then produces the active-low read or write strobe with the programmed width and returns the outcome over a valid/ready response channel. Read data is captured from the bus while the read strobe is still low. A write that follows a read can be given one extra bus-release cycle, so that the memory has stopped driving the shared data lines before the core drives them.

A plain 8-bit configuration input controls the block, with these fields:
- bit 0: enable.
- bit 1: bus-release wait.
- bits 4:2: write strobe width code.
- bits 7:5: read strobe width code.

While the block is disabled, a mux-select output hands the shared pins to general-purpose I/O. In that state, requests are answered at once with an error flag and cause no bus activity.

Back-pressure rules:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle, so one access is in flight at a time.
- A response is offered with `rsp_valid` and held, with stable `rsp_rdata` and `rsp_err`, until `rsp_ready` is high on a clock edge.
- The next request is taken only after the response has been accepted.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Both strobes are high, and both output enables are 0.
- R2: A write holds `bus_wr_n` low for exactly (configuration bits 4:2) + 1 consecutive cycles, from 1 to 8.
- R3: A read holds `bus_rd_n` low for exactly (configuration bits 7:5) + 1 consecutive cycles, from 1 to 8. The read and write strobes are never low together.
- R4: The read data returned is the value on `bus_din` during the last cycle of the read strobe.
- R5: This rule applies when bit 1 is 1 and a write's previous enabled access was a read. The write's strobe then starts two cycles after the accepting edge instead of one. The extra cycle has the address driven and both strobes high.
- R6: With bit 1 at 0, or for write-then-read, read-then-read and write-then-write orders, the strobe starts in the first cycle after the accepting edge.
- R7: `bus_dout_oe` is 1 in every cycle of a write strobe and in no other cycle. `bus_dout` carries the request's write data while the write strobe is low.
- R8: A request taken while bit 0 is 0 is answered in the next cycle with `rsp_err`=1 and no strobe. It does not count as the previous access for R5.
- R9: The configuration is sampled on the accepting edge. Changing it during an access does not alter that access's strobe width, release cycle or ownership.
- R10: `pin_sel_mem` equals bit 0 while the block is idle. It stays 1 for the whole of an access that was accepted enabled.
- R11: `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady while `rsp_ready` is 0. `req_ready` is 0 from the accepting edge until the response is taken.
- R12: `bus_addr_oe` is 1 and `bus_addr` equals the request address in every release cycle and every strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration: enable, release wait, write width, read width |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Captured read data (0 for writes and errors) |
| rsp_err | output | 1 | Request was taken while disabled |
| pin_sel_mem | output | 1 | 1 = shared pins carry the memory bus, 0 = general-purpose I/O |
| bus_addr | output | AW | Address to the pins |
| bus_addr_oe | output | 1 | Address output enable |
| bus_dout | output | DW | Write data to the pins |
| bus_dout_oe | output | 1 | Data output enable |
| bus_din | input | DW | Data from the pins |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
Counted from the accepting edge, the bus timing is as follows:
- The strobe or the release cycle is visible in the first cycle after that edge.
- The strobe begins in the second cycle after that edge when a release cycle is inserted.
- The response appears in the cycle after the last strobe cycle.
- A rejected request is answered in the first cycle after that edge.

The bench samples every output on the falling edge after each rising edge and counts, cycle by cycle, the cycles before the strobe, the strobe cycles and the output-enable cycles. It then compares these counts with widths and release expectations computed from the configuration captured at acceptance. The bus model changes `bus_din` on every strobe cycle, so only a capture in the last strobe cycle returns the value the bench expects.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int WCODE_W = 3;

  typedef struct packed {
    logic [WCODE_W-1:0] rd_code;
    logic [WCODE_W-1:0] wr_code;
    logic               release_wait;
    logic               enable;
  } xmem_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RELEASE = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RESP    = 2'd3
  } xmem_state_e;

  function automatic logic [WCODE_W-1:0] pick_code(input xmem_cfg_t c, input logic is_wr);
    return is_wr ? c.wr_code : c.rd_code;
  endfunction

endpackage

// File: rtl/xmem_strobe_timer.sv
module xmem_strobe_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_code,
  input  logic          run,
  output logic          last
);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_code;
    end else if (run && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last = (remain_q == '0);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  xmem_cfg_t   cfg_now,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        rsp_ready,
  input  logic        tmr_last,
  output xmem_state_e state,
  output logic        accept,
  output logic        op_wr,
  output logic        en_held,
  output logic        capture
);
  xmem_state_e state_q, state_d;
  logic        op_wr_q;
  logic        en_q;
  logic        prev_read_q;
  logic        strobe_done;

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign strobe_done = (state_q == ST_STROBE) && tmr_last;
  assign capture     = strobe_done && !op_wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!cfg_now.enable)
            state_d = ST_RESP;
          else if (req_write && prev_read_q && cfg_now.release_wait)
            state_d = ST_RELEASE;
          else
            state_d = ST_STROBE;
        end
      end
      ST_RELEASE: state_d = ST_STROBE;
      ST_STROBE:  if (tmr_last) state_d = ST_RESP;
      ST_RESP:    if (rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_wr_q     <= 1'b0;
      en_q        <= 1'b0;
      prev_read_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_wr_q <= req_write;
        en_q    <= cfg_now.enable;
      end
      if (strobe_done)
        prev_read_q <= !op_wr_q;
    end
  end

  assign state   = state_q;
  assign op_wr   = op_wr_q;
  assign en_held = en_q;
endmodule

// File: rtl/xmem_datapath.sv
module xmem_datapath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          accept_err,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        rdata_q <= '0;
        err_q   <= accept_err;
      end else if (capture) begin
        rdata_q <= bus_din;
      end
    end
  end
endmodule

// File: rtl/xmem_strobe_ctrl.sv
module xmem_strobe_ctrl
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_byte,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          pin_sel_mem,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_rd_n,
  output logic          bus_wr_n
);
  xmem_cfg_t   cfg_now;
  xmem_state_e state;
  logic        accept, op_wr, en_held, capture, tmr_last;
  logic        in_strobe, in_release;

  assign cfg_now = xmem_cfg_t'(cfg_byte);

  xmem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_now(cfg_now),
    .req_valid(req_valid), .req_write(req_write), .rsp_ready(rsp_ready),
    .tmr_last(tmr_last), .state(state), .accept(accept), .op_wr(op_wr),
    .en_held(en_held), .capture(capture)
  );

  xmem_strobe_timer #(.CW(WCODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_code(pick_code(cfg_now, req_write)),
    .run(state == ST_STROBE), .last(tmr_last)
  );

  xmem_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .accept_err(!cfg_now.enable),
    .req_addr(req_addr), .req_wdata(req_wdata), .capture(capture),
    .bus_din(bus_din), .addr_q(bus_addr), .wdata_q(bus_dout),
    .rdata_q(rsp_rdata), .err_q(rsp_err)
  );

  assign in_strobe  = (state == ST_STROBE);
  assign in_release = (state == ST_RELEASE);

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign bus_rd_n    = !(in_strobe && !op_wr);
  assign bus_wr_n    = !(in_strobe && op_wr);
  assign bus_dout_oe = in_strobe && op_wr;
  assign bus_addr_oe = in_strobe || in_release;
  assign pin_sel_mem = (state == ST_IDLE) ? cfg_now.enable : (cfg_now.enable || en_held);
endmodule

// File: rtl/xmem_strobe_chk.sv
module xmem_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic rsp_err,
  input logic pin_sel_mem,
  input logic bus_addr_oe,
  input logic bus_dout_oe,
  input logic bus_rd_n,
  input logic bus_wr_n
);
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  p_no_dout_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_dout_oe);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_quiet_when_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && !rsp_valid));

  p_gpio_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sel_mem |-> (bus_rd_n && bus_wr_n));

  p_addr_during_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> bus_addr_oe);
endmodule

bind xmem_strobe_ctrl xmem_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata[7:0]), .rsp_err(rsp_err),
  .pin_sel_mem(pin_sel_mem), .bus_addr_oe(bus_addr_oe), .bus_dout_oe(bus_dout_oe),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/xmem_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_strobe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_byte = 8'h00;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_din = '0;
  logic        req_ready, rsp_valid, rsp_err, pin_sel_mem, bus_addr_oe, bus_dout_oe;
  logic        bus_rd_n, bus_wr_n;
  logic [7:0]  rsp_rdata, bus_dout;
  logic [15:0] bus_addr;

  int checks = 0, errors = 0;
  bit model_prev_rd = 0;
  logic [7:0] rd_base = '0;
  int rdk = 0;

  always #4 clk = ~clk;

  xmem_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_sel_mem(pin_sel_mem),
    .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n)
  );

  function automatic logic [7:0] din_val(input logic [7:0] base, input int k);
    return base + 8'(k * 29);
  endfunction

  always @(negedge clk) begin
    if (!bus_rd_n) begin
      rdk = rdk + 1;
      bus_din = din_val(rd_base, rdk);
    end else begin
      rdk = 0;
      bus_din = 8'h00;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input logic [7:0] cfg, input bit scramble, input int bp);
    int pre = 0, rdc = 0, wrc = 0, oebad = 0, addrbad = 0, doutbad = 0;
    int pinbad = 0, rdybad = 0, cyc = 0;
    bit en = cfg[0];
    int exp_w = wr ? int'(cfg[4:2]) + 1 : int'(cfg[7:5]) + 1;
    bit exp_turn = en && wr && model_prev_rd && cfg[1];
    logic [7:0] saved_rd;
    bit saved_err;
    cfg_byte = cfg; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    rd_base = a[7:0];
    #1;
    chk(req_ready == 1'b1, "R11 ready before accept", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) cfg_byte = ~cfg;
    while (!rsp_valid && cyc < 40) begin
      cyc++;
      if (!bus_rd_n) rdc++;
      if (!bus_wr_n) wrc++;
      if (bus_rd_n && bus_wr_n && rdc == 0 && wrc == 0) begin
        pre++;
        if (!bus_addr_oe || bus_addr != a) addrbad++;
      end
      if ((!bus_rd_n || !bus_wr_n) && (!bus_addr_oe || bus_addr != a)) addrbad++;
      if (bus_dout_oe != !bus_wr_n) oebad++;
      if (!bus_wr_n && bus_dout != d) doutbad++;
      if (en && !pin_sel_mem) pinbad++;
      if (req_ready) rdybad++;
      @(negedge clk);
    end
    chk(pre == int'(exp_turn), "R5/R6 release cycles", pre, int'(exp_turn));
    chk(wrc == ((en && wr) ? exp_w : 0), "R2 write strobe width", wrc, (en && wr) ? exp_w : 0);
    chk(rdc == ((en && !wr) ? exp_w : 0), "R3 read strobe width", rdc, (en && !wr) ? exp_w : 0);
    chk(oebad == 0, "R7 data output enable", oebad, 0);
    chk(doutbad == 0, "R7 write data", doutbad, 0);
    chk(addrbad == 0, "R12 address drive", addrbad, 0);
    chk(pinbad == 0, "R10 pin ownership held", pinbad, 0);
    chk(rdybad == 0, "R11 ready low in access", rdybad, 0);
    chk(rsp_err == !en, "R8 error flag", rsp_err, int'(!en));
    if (!en) chk(cyc == 0, "R8 immediate answer", cyc, 0);
    if (en && !wr)
      chk(rsp_rdata == din_val(a[7:0], exp_w), "R4 read data", rsp_rdata, din_val(a[7:0], exp_w));
    saved_rd = rsp_rdata; saved_err = rsp_err;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == saved_rd && rsp_err == saved_err,
          "R11 response held", rsp_rdata, saved_rd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R11 response taken", rsp_valid, 0);
    if (en) model_prev_rd = !wr;
    cfg_byte = cfg;
  endtask

  function automatic logic [7:0] mk_cfg(input int rdw, input int wrw, input bit rel, input bit en);
    return {3'(rdw - 1), 3'(wrw - 1), rel, en};
  endfunction

  initial begin
    #200_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1 reset handshake", req_ready, 1);
    chk(bus_rd_n && bus_wr_n && !bus_addr_oe && !bus_dout_oe, "R1 reset bus idle", bus_rd_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_byte = 8'h00; #1;
    chk(pin_sel_mem == 0, "R10 idle disabled", pin_sel_mem, 0);
    cfg_byte = 8'h01; #1;
    chk(pin_sel_mem == 1, "R10 idle enabled", pin_sel_mem, 1);
    // directed: widths at extremes
    do_access(0, 16'h0010, 8'h00, mk_cfg(1, 1, 0, 1), 0, 0);
    do_access(1, 16'h0020, 8'hA5, mk_cfg(8, 8, 0, 1), 0, 2);
    do_access(0, 16'h0033, 8'h00, mk_cfg(8, 1, 0, 1), 0, 0);
    do_access(1, 16'h0044, 8'h3C, mk_cfg(1, 1, 0, 1), 0, 0);   // R6 turn off after read
    // directed: release wait orders
    do_access(0, 16'h0051, 8'h00, mk_cfg(3, 2, 1, 1), 0, 0);
    do_access(1, 16'h0052, 8'h11, mk_cfg(3, 2, 1, 1), 0, 0);   // R5 read->write
    do_access(1, 16'h0053, 8'h22, mk_cfg(3, 2, 1, 1), 0, 0);   // R6 write->write
    do_access(0, 16'h0054, 8'h00, mk_cfg(3, 2, 1, 1), 0, 0);   // R6 write->read
    do_access(0, 16'h0055, 8'h00, mk_cfg(3, 2, 1, 1), 0, 0);   // R6 read->read
    // R8: disabled request does not count as previous access
    do_access(1, 16'h0056, 8'h33, mk_cfg(3, 2, 1, 0), 0, 1);
    do_access(1, 16'h0057, 8'h44, mk_cfg(3, 2, 1, 1), 0, 0);   // still gets release
    // R9: configuration scrambled mid-access
    do_access(0, 16'h0060, 8'h00, mk_cfg(5, 2, 1, 1), 1, 0);
    do_access(1, 16'h0061, 8'h55, mk_cfg(5, 7, 1, 1), 1, 1);
    // random phase
    for (int n = 0; n < 200; n++) begin
      logic [7:0] c = 8'($urandom);
      c[0] = ($urandom % 8) != 0;
      do_access(1'($urandom), 16'($urandom), 8'($urandom), c, 1'($urandom), $urandom % 4);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule